// File: doc/BRIEF.md
# Speculative Pipelined Loop Controller

This block sequences one loop invocation at a time for a downstream datapath. After a start request is taken with its iteration bound, it launches one iteration per clock. Each iteration carries its index and a kill flag. The launch path does not wait for the loop's exit test. The test `index < bound` is carried out in its own pipeline, which splits the unsigned comparison into slices, most significant slice first, across a parameterised number of stages. The launch path therefore keeps issuing while the test is still in flight.

Because the exit result arrives late, a fixed number of iterations past the last useful one are issued. Each of them is marked with the kill flag so that the datapath throws it away. Once the exit result arrives, launching stops and the controller drains for a fixed number of quiet cycles. It then emits a one-cycle done pulse and takes the next start request.

When an outer sequencer holds the start request high, each inner invocation of N iterations costs N plus a constant overhead. A nest of N by N therefore takes N × (N + s) cycles, where s = EXIT_DEPTH + FLUSH_CYC + 1.

Top module: `spec_loop_ctrl`

## Requirements
- R1: A start request is taken only at a clock edge where `start_ready` is high, which happens only while the controller is idle. `start_valid` raised during an invocation has no effect on that invocation or on any later cycle.
- R2: Iterations are issued on consecutive cycles, with `iter_index` counting 0, 1, 2, … in steps of one. The first iteration appears in the cycle right after the edge that takes the start request.
- R3: Every issued iteration with index below the bound has `iter_kill` = 0, and every issued iteration with index at or above the bound has `iter_kill` = 1. Exactly `bound` unkilled iterations are issued.
- R4: Exactly EXIT_DEPTH killed iterations follow the last unkilled one. `iter_valid` is low from the next cycle on.
- R5: After the last issued iteration, `iter_valid` and `done` stay low for exactly FLUSH_CYC cycles. `done` is then high for one cycle, and `start_ready` is high in that same cycle. Measured from the first issued iteration (cycle 0), done falls in cycle bound + EXIT_DEPTH + FLUSH_CYC.
- R6: A bound of zero yields EXIT_DEPTH iterations, all killed, starting at index 0. It is followed by the normal flush and done pulse.
- R7: With `start_valid` held high, the next request is taken at the edge that ends the done cycle. Successive first iterations are EXIT_DEPTH + FLUSH_CYC + bound + 1 cycles apart, so N back-to-back invocations of bound N take N × (N + EXIT_DEPTH + FLUSH_CYC + 1) cycles.
- R8: A synchronous active-high `rst` puts the controller in idle with `start_ready` = 1, `iter_valid` = 0 and `done` = 0. This holds even in the middle of an invocation, and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request to begin an invocation |
| start_ready | output | 1 | High while idle; a request is taken when both are high |
| start_bound | input | IDX_W | Iteration bound, sampled when the request is taken |
| iter_valid | output | 1 | An iteration is issued this cycle |
| iter_index | output | IDX_W | Index of the issued iteration |
| iter_kill | output | 1 | Issued iteration is speculative and must be discarded |
| done | output | 1 | One-cycle pulse when the flush completes |

## Verification
The bench builds the controller with a 32-bit index, an exit pipeline depth of 3 and a flush of 2 cycles. A depth of 3 gives three comparison slices with two registers between them, so the kill run and the stop point both depend on results passing between stages. A short flush keeps back-to-back periods small: a three-by-three nest must take exactly 27 cycles, which the bench counts directly. The bounds 0, 1, 5 and 17 put the first killed index at the very first issue, right after it, and several cycles into an invocation.

// File: rtl/spl_pkg.sv
package spl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } spl_state_e;

  // Running result of an MSB-first magnitude compare.
  typedef struct packed {
    logic decided;
    logic lt;
  } cmp_acc_t;

  localparam int SLICE_MAX = 64;

  // Fold one slice into the running compare; an earlier decision wins.
  function automatic cmp_acc_t slice_step(input cmp_acc_t acc,
                                          input logic [SLICE_MAX-1:0] a,
                                          input logic [SLICE_MAX-1:0] b);
    cmp_acc_t r;
    r = acc;
    if (!acc.decided && (a != b)) begin
      r.decided = 1'b1;
      r.lt      = (a < b);
    end
    return r;
  endfunction

  // Equal on every slice means "not less than".
  function automatic logic lt_resolve(input cmp_acc_t acc);
    return acc.decided & acc.lt;
  endfunction

endpackage

// File: rtl/spl_seq.sv
module spl_seq
  import spl_pkg::*;
#(
  parameter int FLUSH_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_valid,
  input  logic       exit_hit,
  output spl_state_e state,
  output logic       accept,
  output logic       running,
  output logic       done_pulse
);
  localparam int FC_W = (FLUSH_CYC < 2) ? 1 : $clog2(FLUSH_CYC);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FLUSH_CYC - 1);

  logic [FC_W-1:0] flush_cnt;
  logic            flush_last;

  assign accept     = (state == ST_IDLE) & start_valid;
  assign running    = (state == ST_RUN);
  assign flush_last = (state == ST_FLUSH) & (flush_cnt == FC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      flush_cnt  <= '0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= flush_last;
      unique case (state)
        ST_IDLE: if (accept) state <= ST_RUN;
        ST_RUN: begin
          if (exit_hit) begin
            state     <= ST_FLUSH;
            flush_cnt <= '0;
          end
        end
        ST_FLUSH: begin
          if (flush_last) state <= ST_IDLE;
          else            flush_cnt <= flush_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spl_issue.sv
module spl_issue #(
  parameter int IDX_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic [IDX_W-1:0] bound_new,
  input  logic [IDX_W-1:0] bound_cur,
  output logic [IDX_W-1:0] index,
  output logic             kill
);
  function automatic logic [IDX_W-1:0] idx_bump(input logic [IDX_W-1:0] v);
    return v + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] idx_next;
  assign idx_next = idx_bump(index);

  // Kill is a sticky equality hit: cheaper than the magnitude compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
      kill  <= 1'b0;
    end else if (load) begin
      index <= '0;
      kill  <= (bound_new == '0);
    end else if (advance) begin
      index <= idx_next;
      kill  <= kill | (idx_next == bound_cur);
    end
  end
endmodule

// File: rtl/spl_exit_pipe.sv
module spl_exit_pipe
  import spl_pkg::*;
#(
  parameter int IDX_W = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [IDX_W-1:0] bound,
  output logic             res_valid,
  output logic             res_lt
);
  localparam int SLICE_W = (IDX_W + DEPTH - 1) / DEPTH;
  localparam int PAD_W   = SLICE_W * DEPTH;

  logic [PAD_W-1:0] bnd_pad;
  assign bnd_pad = PAD_W'(bound);

  for (genvar j = 0; j < DEPTH; j++) begin : g_stg
    localparam int REM_W = PAD_W - j * SLICE_W;
    localparam int BHI   = PAD_W - 1 - j * SLICE_W;

    logic             v_in;
    logic [REM_W-1:0] idx_in;
    cmp_acc_t         acc_in;
    cmp_acc_t         acc_out;
    logic [SLICE_W-1:0] a_sl;
    logic [SLICE_W-1:0] b_sl;

    if (j == 0) begin : g_head
      assign v_in   = in_valid;
      assign idx_in = REM_W'(in_idx);
      assign acc_in = '0;
    end else begin : g_body
      logic             v_q;
      logic [REM_W-1:0] idx_q;
      cmp_acc_t         acc_q;
      always_ff @(posedge clk) begin
        if (rst || clear) v_q <= 1'b0;
        else              v_q <= g_stg[j-1].v_in;
        idx_q <= g_stg[j-1].idx_in[REM_W-1:0];
        acc_q <= g_stg[j-1].acc_out;
      end
      assign v_in   = v_q;
      assign idx_in = idx_q;
      assign acc_in = acc_q;
    end

    assign a_sl    = idx_in[REM_W-1 -: SLICE_W];
    assign b_sl    = bnd_pad[BHI -: SLICE_W];
    assign acc_out = slice_step(acc_in, SLICE_MAX'(a_sl), SLICE_MAX'(b_sl));
  end

  assign res_valid = g_stg[DEPTH-1].v_in;
  assign res_lt    = lt_resolve(g_stg[DEPTH-1].acc_out);
endmodule

// File: rtl/spec_loop_ctrl.sv
module spec_loop_ctrl
  import spl_pkg::*;
#(
  parameter int IDX_W      = 32,
  parameter int EXIT_DEPTH = 4,
  parameter int FLUSH_CYC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [IDX_W-1:0] start_bound,
  output logic             iter_valid,
  output logic [IDX_W-1:0] iter_index,
  output logic             iter_kill,
  output logic             done
);
  spl_state_e       state;
  logic             accept;
  logic             running;
  logic             exit_hit;
  logic             res_valid;
  logic             res_lt;
  logic             kill_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] bound_q;

  always_ff @(posedge clk) begin
    if (rst)         bound_q <= '0;
    else if (accept) bound_q <= start_bound;
  end

  spl_seq #(.FLUSH_CYC(FLUSH_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_valid(start_valid),
    .exit_hit   (exit_hit),
    .state      (state),
    .accept     (accept),
    .running    (running),
    .done_pulse (done)
  );

  spl_issue #(.IDX_W(IDX_W)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .advance  (running),
    .bound_new(start_bound),
    .bound_cur(bound_q),
    .index    (idx_q),
    .kill     (kill_q)
  );

  spl_exit_pipe #(.IDX_W(IDX_W), .DEPTH(EXIT_DEPTH)) u_exit (
    .clk      (clk),
    .rst      (rst),
    .clear    (exit_hit),
    .in_valid (running),
    .in_idx   (idx_q),
    .bound    (bound_q),
    .res_valid(res_valid),
    .res_lt   (res_lt)
  );

  // First failing compare result stops launch at the next edge.
  assign exit_hit    = running & res_valid & ~res_lt;
  assign start_ready = (state == ST_IDLE);
  assign iter_valid  = running;
  assign iter_index  = idx_q;
  assign iter_kill   = running & kill_q;
endmodule

// File: rtl/spl_chk.sv
module spl_chk #(
  parameter int IDX_W      = 32,
  parameter int EXIT_DEPTH = 4,
  parameter int FLUSH_CYC  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_valid,
  input logic             start_ready,
  input logic [IDX_W-1:0] start_bound,
  input logic             iter_valid,
  input logic [IDX_W-1:0] iter_index,
  input logic             iter_kill,
  input logic             done,
  input logic             accept,
  input logic             exit_hit
);
  logic [15:0]      kill_cnt;
  logic [15:0]      gap_cnt;
  logic [IDX_W-1:0] bnd_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      kill_cnt <= '0;
      gap_cnt  <= '0;
      bnd_seen <= '0;
    end else begin
      if (start_valid && start_ready) begin
        kill_cnt <= '0;
        bnd_seen <= start_bound;
      end else if (iter_valid && iter_kill) begin
        kill_cnt <= kill_cnt + 16'd1;
      end
      if (iter_valid)        gap_cnt <= '0;
      else if (!start_ready) gap_cnt <= gap_cnt + 16'd1;
    end
  end

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (iter_valid || (accept && !start_ready)) |-> !start_ready);

  // R2
  first_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start_valid && start_ready) |=> (iter_valid && iter_index == '0));

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    iter_valid |=> (!iter_valid || iter_index == $past(iter_index) + IDX_W'(1)));

  // R3
  kill_matches_bound_chk: assert property (@(posedge clk) disable iff (rst)
    iter_valid |-> (iter_kill == (iter_index >= bnd_seen)));

  // R4
  exit_stops_issue_chk: assert property (@(posedge clk) disable iff (rst)
    exit_hit |=> !iter_valid);

  // R4
  kill_run_length_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (kill_cnt == 16'(EXIT_DEPTH)));

  // R5
  flush_length_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (gap_cnt == 16'(FLUSH_CYC)));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (start_ready && !iter_valid));
endmodule

bind spec_loop_ctrl spl_chk #(
  .IDX_W     (IDX_W),
  .EXIT_DEPTH(EXIT_DEPTH),
  .FLUSH_CYC (FLUSH_CYC)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_valid(start_valid),
  .start_ready(start_ready),
  .start_bound(start_bound),
  .iter_valid (iter_valid),
  .iter_index (iter_index),
  .iter_kill  (iter_kill),
  .done       (done),
  .accept     (accept),
  .exit_hit   (exit_hit)
);

// File: tb/spec_loop_ctrl_tb_top.sv
module spec_loop_ctrl_tb_top;
  localparam int IDX_W = 32;
  localparam int D     = 3;
  localparam int S     = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_valid = 1'b0;
  logic [IDX_W-1:0] start_bound = '0;
  logic             start_ready;
  logic             iter_valid;
  logic [IDX_W-1:0] iter_index;
  logic             iter_kill;
  logic             done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spec_loop_ctrl #(.IDX_W(IDX_W), .EXIT_DEPTH(D), .FLUSH_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .start_bound(start_bound), .iter_valid(iter_valid), .iter_index(iter_index),
    .iter_kill(iter_kill), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One invocation; poke raises a foreign start while busy (R1).
  task automatic run_one(input int bnd, input bit poke, input string tag);
    int live = 0, kills = 0, bad_idx = 0, order_bad = 0;
    int first_c = -1, last_c = -1, done_c = -1, n_issue = 0;
    @(negedge clk);
    start_valid = 1'b1;
    start_bound = IDX_W'(bnd);
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    for (int c = 0; c < 500; c++) begin
      if (poke && c == 2) begin start_valid = 1'b1; start_bound = 32'd100; end
      if (poke && c == 5) start_valid = 1'b0;
      if (iter_valid) begin
        if (first_c < 0) first_c = c;
        last_c = c;
        if (iter_index != IDX_W'(n_issue)) bad_idx++;
        n_issue++;
        if (iter_kill) kills++;
        else begin
          live++;
          if (kills != 0) order_bad++;
        end
      end
      if (done) begin done_c = c; break; end
      @(negedge clk);
    end
    chk("R2", {tag, " first issue cycle"}, first_c, (bnd + D > 0) ? 0 : -1);
    chk("R2", {tag, " index sequence errors"}, bad_idx, 0);
    chk("R3", {tag, " unkilled count"}, live, bnd);
    chk("R3", {tag, " killed before live"}, order_bad, 0);
    chk("R4", {tag, " killed count"}, kills, D);
    chk("R4", {tag, " last issue cycle"}, last_c, bnd + D - 1);
    chk("R5", {tag, " done cycle"}, done_c, bnd + D + S);
    chk("R5", {tag, " ready with done"}, start_ready, 1);
    @(negedge clk);
    chk("R5", {tag, " done one cycle"}, done, 0);
    if (poke) begin
      int extra = 0;
      for (int c = 0; c < 12; c++) begin
        if (iter_valid || done) extra++;
        @(negedge clk);
      end
      chk("R1", {tag, " activity after busy start"}, extra, 0);
    end
  endtask

  task automatic t_reset_state();
    chk("R8", "reset ready", start_ready, 1);
    chk("R8", "reset valid", iter_valid, 0);
    chk("R8", "reset done", done, 0);
  endtask

  task automatic t_zero_bound();
    run_one(0, 1'b0, "R6 bound0");
  endtask

  task automatic t_back_to_back();
    localparam int N = 3;
    int starts[N];
    int ns = 0, nd = 0, last_done = -1;
    @(negedge clk);
    start_valid = 1'b1;
    start_bound = IDX_W'(N);
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < 300 && nd < N; c++) begin
      if (iter_valid && iter_index == '0 && ns < N) begin starts[ns] = c; ns++; end
      if (done) begin
        nd++;
        last_done = c;
        if (nd == N) start_valid = 1'b0;
      end
      @(negedge clk);
    end
    chk("R7", "starts seen", ns, N);
    chk("R7", "period 1", starts[1] - starts[0], N + D + S + 1);
    chk("R7", "period 2", starts[2] - starts[1], N + D + S + 1);
    chk("R7", "nest cycles", last_done - starts[0] + 1, N * (N + D + S + 1));
    repeat (15) @(negedge clk);
    chk("R7", "idle after release", iter_valid, 0);
  endtask

  task automatic t_reset_mid_run();
    int extra = 0;
    @(negedge clk);
    start_valid = 1'b1;
    start_bound = 32'd50;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8", "mid-run reset valid", iter_valid, 0);
    chk("R8", "mid-run reset ready", start_ready, 1);
    rst = 1'b0;
    for (int c = 0; c < 80; c++) begin
      if (iter_valid || done) extra++;
      @(negedge clk);
    end
    chk("R8", "activity after reset", extra, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    run_one(5, 1'b0, "bound5");
    run_one(1, 1'b0, "bound1");
    t_zero_bound();
    run_one(17, 1'b0, "bound17");
    run_one(6, 1'b1, "R1 busy-start");
    t_back_to_back();
    t_reset_mid_run();
    run_one(2, 1'b0, "after reset");
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule